// File: doc/BRIEF.md
# Halfword-Swapping Burst Write Adapter

This adapter connects a peripheral that produces data as a stream of 16-bit halfwords to a memory port that writes bytes. A command supplies a start address, a byte count and a bypass flag. The adapter builds the memory address by ORing the command address with a high-address base input. In the default mode it forces the address and the count to even values and exchanges the two bytes of every halfword. The result goes out as a series of write bursts, each no larger than a fixed number of bytes.

When bypass is set, the address, the count and the byte order pass through unchanged. Each burst is a single request with a valid/ready handshake. A burst carries an address, a byte count and a data vector. Byte `i` of the data vector belongs at address `mem_addr + i`. A one-cycle done pulse marks the end of each command.

Top module: `dma16_swap_adapter`

## Requirements
- R1: The address of the first burst of a command is `cmd_addr | hi_base`, sampled when the command is accepted. In swap mode, bit 0 of this address is then cleared.
- R2: With `cmd_bypass`=1, the address and the byte count are used unmodified. Data byte `2k` holds bits [7:0] of halfword `k`, and byte `2k+1` holds bits [15:8].
- R3: With `cmd_bypass`=0, bit 0 of both the address and the byte count is cleared before any burst is formed.
- R4: With `cmd_bypass`=0, data byte `2k` holds bits [15:8] of halfword `k`, and byte `2k+1` holds bits [7:0].
- R5: A command is issued as successive bursts. Each burst's length is the smaller of the remaining count and 64 (`BURST_BYTES`). Each burst's address is the previous burst's address plus the previous burst's length.
- R6: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_len` and `mem_data` hold. A new burst is presented only after the previous one is accepted.
- R7: A command whose effective count is zero, including an odd count of 1 in swap mode, issues no burst. It still produces a done pulse in the cycle after acceptance.
- R8: `done` is high for exactly the cycle after the last burst of a command is accepted, and at no other time except as described in R7.
- R9: A command consumes exactly ceil(count/2) halfwords. Data bytes at positions at or beyond `mem_len` are zero.
- R10: After reset, `cmd_ready`=1, `in_ready`=0, `mem_valid`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_base | input | ADDR_W | High-address base, ORed into the command address |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Adapter idle, able to take a command |
| cmd_addr | input | ADDR_W | Peripheral start address |
| cmd_len | input | LEN_W | Byte count |
| cmd_bypass | input | 1 | 1 = no alignment and no swap |
| in_valid | input | 1 | Halfword offered |
| in_ready | output | 1 | Adapter accepts a halfword |
| in_data | input | 16 | Halfword from the peripheral |
| mem_valid | output | 1 | Burst request valid |
| mem_ready | input | 1 | Memory accepts the burst |
| mem_addr | output | ADDR_W | Burst start byte address |
| mem_len | output | clog2(BURST_BYTES+1) | Burst byte count |
| mem_data | output | 8*BURST_BYTES | Burst bytes, byte i at bits [8i+7:8i] |
| done | output | 1 | One-cycle command completion pulse |

## Verification
The hardest case to reach is a multi-burst command in which memory stalls a burst partway through and the final burst is short. Only this combination checks that the held request stays stable, that the address step uses the correct length, and that done lands after the last acceptance. The stimulus reaches it with counts of 129 and 150 bytes, with `mem_ready` asserted only every third cycle and halfwords offered with gaps. Zero-effective-length commands, including a swap-mode count of 1, are mixed in to confirm that no burst appears.

// File: rtl/dma16_pkg.sv
package dma16_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_SEND = 2'd2
  } dma16_state_e;
endpackage

// File: rtl/dma16_addr_form.sv
module dma16_addr_form #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic [ADDR_W-1:0] raw_addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  raw_len,
  input  logic              bypass,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [LEN_W-1:0]  eff_len
);
  logic [ADDR_W-1:0] joined;

  always_comb begin
    joined = raw_addr | base;
    if (bypass) begin
      eff_addr = joined;
      eff_len  = raw_len;
    end else begin
      eff_addr = {joined[ADDR_W-1:1], 1'b0};
      eff_len  = {raw_len[LEN_W-1:1], 1'b0};
    end
  end
endmodule

// File: rtl/dma16_pack.sv
module dma16_pack #(
  parameter int BURST_BYTES = 64,
  localparam int HW_PER = BURST_BYTES / 2,
  localparam int IDX_W  = $clog2(HW_PER + 1),
  localparam int BL_W   = $clog2(BURST_BYTES + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [15:0]              wr_data,
  input  logic                     swap,
  input  logic [BL_W-1:0]          keep_len,
  output logic [BURST_BYTES*8-1:0] out_data
);
  logic [15:0] lane_word;

  always_comb begin
    lane_word = swap ? {wr_data[7:0], wr_data[15:8]} : wr_data;
  end

  for (genvar g = 0; g < HW_PER; g++) begin : g_slot
    logic [15:0] slot_q;
    logic [15:0] slot_d;
    logic        slot_en;

    always_comb begin
      slot_en = clr || (wr_en && (wr_idx == IDX_W'(g)));
      slot_d  = clr ? 16'h0000 : lane_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= 16'h0000;
      else if (slot_en) slot_q <= slot_d;
    end

    always_comb begin
      out_data[16*g +: 8]     = (BL_W'(2*g)     < keep_len) ? slot_q[7:0]  : 8'h00;
      out_data[16*g + 8 +: 8] = (BL_W'(2*g + 1) < keep_len) ? slot_q[15:8] : 8'h00;
    end
  end
endmodule

// File: rtl/dma16_swap_adapter.sv
module dma16_swap_adapter #(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int BURST_BYTES = 64
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [ADDR_W-1:0]                  hi_base,
  input  logic                               cmd_valid,
  output logic                               cmd_ready,
  input  logic [ADDR_W-1:0]                  cmd_addr,
  input  logic [LEN_W-1:0]                   cmd_len,
  input  logic                               cmd_bypass,
  input  logic                               in_valid,
  output logic                               in_ready,
  input  logic [15:0]                        in_data,
  output logic                               mem_valid,
  input  logic                               mem_ready,
  output logic [ADDR_W-1:0]                  mem_addr,
  output logic [$clog2(BURST_BYTES+1)-1:0]   mem_len,
  output logic [BURST_BYTES*8-1:0]           mem_data,
  output logic                               done
);
  import dma16_pkg::*;

  localparam int HW_PER = BURST_BYTES / 2;
  localparam int IDX_W  = $clog2(HW_PER + 1);
  localparam int BL_W   = $clog2(BURST_BYTES + 1);

  dma16_state_e      state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic              byp_q, byp_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              done_q, done_d;

  logic [ADDR_W-1:0] eff_addr;
  logic [LEN_W-1:0]  eff_len;
  logic [BL_W-1:0]   chunk_len;
  logic [BL_W:0]     chunk_round;
  logic [IDX_W-1:0]  need_hw;
  logic              last_chunk;
  logic              pack_clr, pack_wr;

  dma16_addr_form #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_addr (
    .raw_addr (cmd_addr),
    .base     (hi_base),
    .raw_len  (cmd_len),
    .bypass   (cmd_bypass),
    .eff_addr (eff_addr),
    .eff_len  (eff_len)
  );

  dma16_pack #(.BURST_BYTES(BURST_BYTES)) u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (pack_clr),
    .wr_en    (pack_wr),
    .wr_idx   (idx_q),
    .wr_data  (in_data),
    .swap     (!byp_q),
    .keep_len (chunk_len),
    .out_data (mem_data)
  );

  // burst sizing from the remaining count
  always_comb begin
    chunk_len   = (rem_q >= LEN_W'(BURST_BYTES)) ? BL_W'(BURST_BYTES) : BL_W'(rem_q);
    chunk_round = {1'b0, chunk_len} + 1'b1;
    need_hw     = IDX_W'(chunk_round >> 1);
    last_chunk  = (rem_q == LEN_W'(chunk_len));
  end

  // next-state logic
  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    rem_d    = rem_q;
    byp_d    = byp_q;
    idx_d    = idx_q;
    done_d   = 1'b0;
    pack_clr = 1'b0;
    pack_wr  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          if (eff_len == '0) begin
            done_d = 1'b1;
          end else begin
            state_d = ST_FILL;
            addr_d  = eff_addr;
            rem_d   = eff_len;
            byp_d   = cmd_bypass;
            idx_d   = '0;
          end
        end
      end
      ST_FILL: begin
        if (in_valid) begin
          pack_wr = 1'b1;
          idx_d   = idx_q + 1'b1;
          if ((idx_q + 1'b1) == need_hw) state_d = ST_SEND;
        end
      end
      ST_SEND: begin
        if (mem_ready) begin
          addr_d   = addr_q + ADDR_W'(chunk_len);
          rem_d    = rem_q - LEN_W'(chunk_len);
          idx_d    = '0;
          pack_clr = 1'b1;
          if (last_chunk) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d = ST_FILL;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      byp_q   <= 1'b0;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      rem_q   <= rem_d;
      byp_q   <= byp_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
    end
  end

  always_comb begin
    cmd_ready = (state_q == ST_IDLE);
    in_ready  = (state_q == ST_FILL);
    mem_valid = (state_q == ST_SEND);
    mem_addr  = addr_q;
    mem_len   = chunk_len;
    done      = done_q;
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_len) && $stable(mem_data));

  assert_burst_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_len != '0) && (mem_len <= BL_W'(BURST_BYTES)));

  assert_even_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !byp_q |-> !mem_addr[0] && !mem_len[0]);

  assert_done_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(cmd_valid && cmd_ready) || $past(mem_valid && mem_ready));

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !mem_valid && !cmd_ready);
endmodule

// File: tb/sim_dma16_swap_adapter.sv
module sim_dma16_swap_adapter;
  localparam int AW = 32;
  localparam int LW = 16;
  localparam int BB = 64;
  localparam int BLW = $clog2(BB + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] hi_base;
  logic cmd_valid, cmd_ready, cmd_bypass;
  logic [AW-1:0] cmd_addr;
  logic [LW-1:0] cmd_len;
  logic in_valid, in_ready;
  logic [15:0] in_data;
  logic mem_valid, mem_ready;
  logic [AW-1:0] mem_addr;
  logic [BLW-1:0] mem_len;
  logic [BB*8-1:0] mem_data;
  logic done;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dma16_swap_adapter #(.ADDR_W(AW), .LEN_W(LW), .BURST_BYTES(BB)) u0 (
    .clk(clk), .rst_n(rst_n), .hi_base(hi_base),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .cmd_bypass(cmd_bypass),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_len(mem_len), .mem_data(mem_data), .done(done)
  );

  task automatic chk(input bit ok, input string what, input logic [BB*8-1:0] act, input logic [BB*8-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // behavioural model queues
  logic [AW-1:0]   q_addr[$];
  int              q_len[$];
  logic [BB*8-1:0] q_data[$];
  logic [15:0]     hw[$];

  task automatic run_case(input logic [AW-1:0] a, input int len, input bit byp,
                          input logic [AW-1:0] base, input int igap, input int mgap, input int seed);
    logic [AW-1:0] ea;
    int el, nhw, off, fed, cyc;
    bit sent, pend, finished, hold;
    logic [AW-1:0] hold_addr;
    ea = a | base;
    el = len;
    if (!byp) begin
      ea[0] = 1'b0;
      el = len & ~1;
    end
    nhw = (el + 1) / 2;
    hw.delete();
    for (int k = 0; k < nhw; k++) hw.push_back({8'(2*k + 1 + seed*7), 8'(2*k + seed*13 + 128)});
    off = 0;
    while (off < el) begin
      int c;
      logic [BB*8-1:0] d;
      c = (el - off > BB) ? BB : el - off;
      d = '0;
      for (int j = 0; j < c; j++) begin
        int g;
        g = off + j;
        d[8*j +: 8] = (((g % 2) == 0) == byp) ? hw[g/2][7:0] : hw[g/2][15:8];
      end
      q_addr.push_back(ea + AW'(off));
      q_len.push_back(c);
      q_data.push_back(d);
      off += c;
    end
    hi_base  = base;
    cmd_addr = a;
    cmd_len  = LW'(len);
    cmd_bypass = byp;
    sent = 0; pend = 0; finished = 0; hold = 0; fed = 0; cyc = 0; hold_addr = '0;
    while (!finished && cyc < 3000) begin
      bit exp_done;
      @(negedge clk);
      cyc++;
      exp_done = pend;
      pend = 0;
      chk(done === exp_done, "R8/R7 done timing", BB*8'(done), BB*8'(exp_done));
      if (exp_done) finished = 1;
      if (hold) begin
        chk(mem_valid === 1'b1 && mem_addr === hold_addr, "R6 held request",
            BB*8'(mem_addr), BB*8'(hold_addr));
      end
      if (mem_valid) begin
        if (q_addr.size() == 0) begin
          chk(1'b0, "R7 unexpected burst", BB*8'(mem_addr), '0);
        end else begin
          chk(mem_addr === q_addr[0], "R1/R5 burst address", BB*8'(mem_addr), BB*8'(q_addr[0]));
          chk(int'(mem_len) == q_len[0], "R3/R5 burst length", BB*8'(mem_len), BB*8'(q_len[0]));
          chk(mem_data === q_data[0], byp ? "R2/R9 burst data" : "R4/R9 burst data", mem_data, q_data[0]);
        end
      end
      // drive for the coming edge
      if (!sent) begin
        cmd_valid = 1'b1;
        if (cmd_ready) begin
          sent = 1;
          if (el == 0) pend = 1;
        end
      end else begin
        cmd_valid = 1'b0;
      end
      if (fed < nhw && (cyc % igap) == 0) begin
        in_valid = 1'b1;
        in_data  = hw[fed];
        if (in_ready) fed++;
      end else begin
        in_valid = 1'b0;
      end
      mem_ready = ((cyc % mgap) == 0);
      if (mem_valid && mem_ready && q_addr.size() != 0) begin
        void'(q_addr.pop_front());
        void'(q_len.pop_front());
        void'(q_data.pop_front());
        if (q_addr.size() == 0) pend = 1;
      end
      hold = mem_valid && !mem_ready;
      hold_addr = mem_addr;
    end
    if (!finished) chk(1'b0, "R8 command never completed", '0, 1);
    chk(fed == nhw, "R9 halfwords consumed", BB*8'(fed), BB*8'(nhw));
    cmd_valid = 1'b0;
    in_valid  = 1'b0;
    mem_ready = 1'b0;
    @(negedge clk);
    chk(done === 1'b0, "R8 done is one cycle", BB*8'(done), '0);
    chk(in_ready === 1'b0 && mem_valid === 1'b0, "R9 idle after command",
        BB*8'({in_ready, mem_valid}), '0);
    q_addr.delete(); q_len.delete(); q_data.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    hi_base = '0; cmd_valid = 1'b0; cmd_addr = '0; cmd_len = '0; cmd_bypass = 1'b0;
    in_valid = 1'b0; in_data = '0; mem_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready === 1'b1 && in_ready === 1'b0 && mem_valid === 1'b0 && done === 1'b0,
        "R10 reset state", BB*8'({cmd_ready, in_ready, mem_valid, done}), BB*8'(4'b1000));
    run_case(32'h0000_0100, 8,   0, 32'h8000_0000, 1, 1, 1);  // R1 R4 basic swap
    run_case(32'h0000_0103, 7,   1, 32'h4000_0000, 2, 1, 2);  // R2 odd bypass
    run_case(32'h0000_0201, 9,   0, 32'h0000_0000, 1, 2, 3);  // R3 alignment
    run_case(32'h0000_1000, 150, 0, 32'h1000_0000, 2, 3, 4);  // R5 R6 multi-burst
    run_case(32'h0000_2001, 129, 1, 32'h0000_0000, 1, 3, 5);  // R5 R9 bypass tail
    run_case(32'h0000_0300, 1,   0, 32'h0000_0000, 1, 1, 6);  // R7 trimmed to zero
    run_case(32'h0000_0400, 0,   1, 32'h0000_0000, 1, 1, 7);  // R7 zero bypass
    run_case(32'h0000_0500, 64,  0, 32'h0000_0000, 3, 2, 8);  // R5 exact burst
    run_case(32'h0000_00F0, 6,   0, 32'h0000_0F0F, 1, 1, 9);  // R1 OR overlap
    run_case(32'h0000_0600, 2,   1, 32'h0000_0000, 1, 4, 10); // R2 single halfword
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule